// File: doc/BRIEF.md
# Two-Wire Wiper Register Slave with Commit-Busy Flag

This block is the serial-bus front end of a 128-position digital potentiometer. It watches a two-wire bus (SCL, SDA), recognises START, repeated START and STOP, and answers only an identification byte made of a fixed 5-bit prefix, two strap pins and a read/write flag. Behind it are three byte-wide registers: a stored wiper value, a live wiper value that drives the tap output, and a control register whose bit 5 signals a commit in progress.

A host writes one register per transaction: identification byte with R/W=0, register address, one data byte, STOP. To read, the host sets the address the same way, issues a repeated START and an identification byte with R/W=1, then clocks out bytes for as long as it acknowledges them. A write to the stored wiper does not take effect at once. It is held pending. The STOP that ends the transaction starts a commit timer of a fixed number of clock cycles, and the stored value changes only when that timer expires. The host polls the control register until bit 5 clears and then reads back the stored value.

Top module: `pot_i2c_slave`

## Requirements
- R1: After reset, SDA is released, the live wiper output and both wiper registers hold 0x40, and the control register reads 0x00.
- R2: An identification byte is acknowledged only when its bits [7:3] equal 5'b01010 and bits [2:1] equal the strap pins. Otherwise SDA stays released until the next START.
- R3: A write of identification (bit 0 = 0), address and one data byte is acknowledged after each byte. A write to address 1 (live wiper) updates the wiper output before the STOP.
- R4: A read starts at the last address set and returns bytes MSB first while the master acknowledges. The address advances by one per byte and wraps from 2 to 0.
- R5: An accepted write to address 0 (stored wiper) sets control bit 5 at once. The commit timer starts at STOP and runs for BUSY_CYCLES cycles. Address 0 then reads the new value and bit 5 reads 0.
- R6: While control bit 5 is 1, a data byte addressed to address 0 is not acknowledged and is discarded. Data bytes to address 1 are still acknowledged and applied.
- R7: An address byte of 3 or more is not acknowledged, and the data byte after it is ignored.
- R8: The slave changes its SDA drive only while the synchronised SCL is low.
- R9: Writes to address 2 are acknowledged but change nothing. Bit 7 of a wiper data byte is dropped and reads back as 0.
- R10: A second data byte in one write transaction is not acknowledged and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| addr_pins_i | input | 2 | Strap pins matched against identification bits [2:1] |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| wiper_o | output | 7 | Live tap position |

## Verification
On every cycle the assertions check that the slave releases SDA when idle or ignoring a transaction, that its SDA drive moves only while the synchronised SCL is low, that the commit timer only starts after a STOP and never runs longer than its count, that the busy flag covers the whole timer, that the address pointer stays inside the register space, and that a rejected stored-wiper write leaves SDA released in its acknowledge slot. Only the bench scenarios can show byte values on the wire, wrap-around of sequential reads, the point at which the stored value appears, strap-pin matching, and the dropping of extra or out-of-range bytes. The bench compares these against a behavioural transaction model and checks the wiper output against that model on every clock between transactions.

// File: rtl/pot_i2c_pkg.sv
package pot_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ID, ST_ADDR, ST_WDATA, ST_READ, ST_WAIT
  } ctl_state_e;

  localparam int NUM_REGS = 3;
  localparam int REG_NV   = 0;
  localparam int REG_VOL  = 1;
  localparam int REG_CTRL = 2;
  localparam int WIP_BIT  = 5;
  localparam int AW       = $clog2(NUM_REGS);
endpackage

// File: rtl/pot_i2c_line_sync.sv
module pot_i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_i;
      sda_pipe[0] <= sda_i;
      for (int i = 1; i < STAGES; i++) begin
        scl_pipe[i] <= scl_pipe[i-1];
        sda_pipe[i] <= sda_pipe[i-1];
      end
      scl_d <= scl_pipe[STAGES-1];
      sda_d <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/pot_i2c_busy_timer.sv
module pot_i2c_busy_timer #(
  parameter int BUSY_CYCLES = 2000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (start_i && !busy_o)    cnt_q <= CW'(BUSY_CYCLES);
    else if (busy_o)                cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/pot_i2c_regfile.sv
module pot_i2c_regfile
  import pot_i2c_pkg::*;
#(
  parameter int             WIPER_W     = 7,
  parameter logic [WIPER_W-1:0] WIPER_RESET = 7'h40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic               stop_i,
  input  logic               busy_i,
  input  logic               done_i,
  output logic               wr_ok_o,
  output logic               launch_o,
  output logic               wip_o,
  output logic [7:0]         rd_data_o,
  output logic [WIPER_W-1:0] wiper_o
);
  logic [WIPER_W-1:0] nv_q, vol_q, pend_val_q;
  logic               pend_q;

  assign wip_o    = pend_q | busy_i;
  assign wr_ok_o  = !((addr_i == AW'(REG_NV)) && wip_o);
  assign launch_o = stop_i & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nv_q       <= WIPER_RESET;
      vol_q      <= WIPER_RESET;
      pend_val_q <= WIPER_RESET;
      pend_q     <= 1'b0;
    end else begin
      if (launch_o) pend_q <= 1'b0;
      if (done_i)   nv_q   <= pend_val_q;
      if (wr_en_i && wr_ok_o) begin
        case (addr_i)
          AW'(REG_NV): begin
            pend_q     <= 1'b1;
            pend_val_q <= wr_data_i[WIPER_W-1:0];
          end
          AW'(REG_VOL): vol_q <= wr_data_i[WIPER_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    case (addr_i)
      AW'(REG_NV):   rd_data_o = 8'(nv_q);
      AW'(REG_VOL):  rd_data_o = 8'(vol_q);
      AW'(REG_CTRL): rd_data_o[WIP_BIT] = wip_o;
      default: ;
    endcase
  end

  assign wiper_o = vol_q;
endmodule

// File: rtl/pot_i2c_slave.sv
module pot_i2c_slave
  import pot_i2c_pkg::*;
#(
  parameter logic [4:0]         ID_PREFIX   = 5'b01010,
  parameter int                 BUSY_CYCLES = 2000000,
  parameter int                 SYNC_STAGES = 2,
  parameter int                 WIPER_W     = 7,
  parameter logic [WIPER_W-1:0] WIPER_RESET = 7'h40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [1:0]         addr_pins_i,
  output logic               sda_oe_o,
  output logic [WIPER_W-1:0] wiper_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, busy_done, launch, wip, wr_ok, wr_en;
  logic [7:0] rd_data;

  ctl_state_e state_q, next_q;
  logic [3:0]    bit_cnt_q;
  logic          in_ack_q, drive_q, mack_q;
  logic [7:0]    shreg_q, tx_q;
  logic [AW-1:0] ptr_q, ptr_inc;
  logic [2:0]    tx_idx;
  logic          byte_done, id_match;

  pot_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  pot_i2c_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(launch), .busy_o(busy), .done_o(busy_done)
  );

  pot_i2c_regfile #(.WIPER_W(WIPER_W), .WIPER_RESET(WIPER_RESET)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .addr_i(ptr_q), .wr_data_i(shreg_q),
    .stop_i(stop_det), .busy_i(busy), .done_i(busy_done), .wr_ok_o(wr_ok),
    .launch_o(launch), .wip_o(wip), .rd_data_o(rd_data), .wiper_o(wiper_o)
  );

  assign byte_done = scl_fall && !in_ack_q && (bit_cnt_q == 4'd8);
  assign id_match  = (shreg_q[7:3] == ID_PREFIX) && (shreg_q[2:1] == addr_pins_i);
  assign wr_en     = !start_det && !stop_det && byte_done && (state_q == ST_WDATA);
  assign ptr_inc   = (ptr_q == AW'(NUM_REGS - 1)) ? '0 : ptr_q + 1'b1;
  assign tx_idx    = 3'd7 - bit_cnt_q[2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      next_q    <= ST_IDLE;
      bit_cnt_q <= '0;
      in_ack_q  <= 1'b0;
      drive_q   <= 1'b0;
      mack_q    <= 1'b0;
      shreg_q   <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
    end else if (start_det) begin
      state_q   <= ST_ID;
      bit_cnt_q <= '0;
      in_ack_q  <= 1'b0;
      drive_q   <= 1'b0;
    end else if (stop_det) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      in_ack_q  <= 1'b0;
      drive_q   <= 1'b0;
    end else if (state_q != ST_IDLE && state_q != ST_WAIT) begin
      if (scl_rise) begin
        if (in_ack_q) begin
          mack_q <= !sda_s;
        end else if (bit_cnt_q < 4'd8) begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
          shreg_q   <= {shreg_q[6:0], sda_s};
        end
      end else if (scl_fall) begin
        if (in_ack_q) begin
          // end of the ninth clock
          in_ack_q  <= 1'b0;
          bit_cnt_q <= '0;
          drive_q   <= 1'b0;
          if (state_q == ST_READ && !mack_q) begin
            state_q <= ST_WAIT;
          end else begin
            state_q <= next_q;
            if (next_q == ST_READ) begin
              tx_q    <= rd_data;
              drive_q <= !rd_data[7];
              ptr_q   <= ptr_inc;
            end
          end
        end else if (bit_cnt_q == 4'd8) begin
          case (state_q)
            ST_ID: begin
              if (id_match) begin
                in_ack_q <= 1'b1;
                drive_q  <= 1'b1;
                next_q   <= shreg_q[0] ? ST_READ : ST_ADDR;
              end else begin
                state_q <= ST_WAIT;
              end
            end
            ST_ADDR: begin
              if (shreg_q < 8'(NUM_REGS)) begin
                in_ack_q <= 1'b1;
                drive_q  <= 1'b1;
                ptr_q    <= shreg_q[AW-1:0];
                next_q   <= ST_WDATA;
              end else begin
                state_q <= ST_WAIT;
              end
            end
            ST_WDATA: begin
              if (wr_ok) begin
                in_ack_q <= 1'b1;
                drive_q  <= 1'b1;
                next_q   <= ST_WAIT;
              end else begin
                state_q <= ST_WAIT;
              end
            end
            ST_READ: begin
              // master's acknowledge slot
              in_ack_q <= 1'b1;
              drive_q  <= 1'b0;
              mack_q   <= 1'b0;
              next_q   <= ST_READ;
            end
            default: state_q <= ST_WAIT;
          endcase
        end else if (state_q == ST_READ && bit_cnt_q != 4'd0) begin
          drive_q <= !tx_q[tx_idx];
        end
      end
    end
  end

  assign sda_oe_o = drive_q;
endmodule

// File: rtl/pot_i2c_slave_chk.sv
module pot_i2c_slave_chk
  import pot_i2c_pkg::*;
#(
  parameter int BUSY_CYCLES = 2000000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s,
  input logic          start_det,
  input logic          stop_det,
  input logic          sda_oe_o,
  input ctl_state_e    state_q,
  input logic [AW-1:0] ptr_q,
  input logic          busy,
  input logic          wip,
  input logic          wr_en
);
  logic [31:0] busy_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= '0;
  end

  assert_idle_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_WAIT) |-> !sda_oe_o);

  assert_oe_scl_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && !$past(start_det || stop_det)) |-> !scl_s);

  assert_busy_after_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(stop_det));

  assert_busy_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run <= 32'(BUSY_CYCLES));

  assert_wip_cover_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> wip);

  assert_ptr_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q < AW'(NUM_REGS));

  assert_nv_reject_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && ptr_q == AW'(REG_NV) && wip) |=> !sda_oe_o);
endmodule

bind pot_i2c_slave pot_i2c_slave_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe_o(sda_oe_o), .state_q(state_q), .ptr_q(ptr_q),
  .busy(busy), .wip(wip), .wr_en(wr_en)
);

// File: tb/tb_pot_i2c_slave.sv
module tb_pot_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 6000;
  localparam int Q = 4;
  localparam logic [7:0] ID_W = 8'h54;  // prefix 01010, pins 10, write
  localparam logic [7:0] ID_R = 8'h55;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [6:0] wiper;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0;
  longint cyc = 0;
  bit live = 1'b0;

  // behavioural model
  logic [6:0] m_vol = 7'h40, m_nv = 7'h40, m_nv_next = 7'h40;
  bit m_pend = 1'b0;
  longint m_busy_until = 0;
  bit m_stop_open = 1'b0;

  pot_i2c_slave #(.BUSY_CYCLES(BUSY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_pins_i(2'b10), .sda_oe_o(sda_oe), .wiper_o(wiper)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (live && rst_n) chk(wiper == m_vol, "R3 wiper per-clock", wiper, m_vol);

  function automatic void sync_model();
    if (m_pend && !m_stop_open && cyc >= m_busy_until) begin
      m_nv = m_nv_next;
      m_pend = 1'b0;
    end
  endfunction

  function automatic bit m_wip();
    sync_model();
    return m_pend;
  endfunction

  function automatic logic [7:0] m_reg(input int a);
    sync_model();
    case (a)
      0: return {1'b0, m_nv};
      1: return {1'b0, m_vol};
      default: return m_pend ? 8'h20 : 8'h00;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = !sda_line;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = !mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q); sda_m = 1'b1;
  endtask

  // write transaction; data_bytes = 1 or 2
  task automatic do_write(input logic [7:0] id, input logic [7:0] addr,
                          input logic [7:0] d0, input logic [7:0] d1,
                          input int nbytes, input string req);
    bit a, e0, e1, e2;
    live = 1'b0;
    e0 = (id[7:1] == ID_W[7:1]) && !id[0];
    e1 = e0 && (addr < 8'd3);
    e2 = e1 && !(addr == 8'd0 && m_wip());
    bus_start();
    send_byte(id, a);   chk(a == e0, {req, " id ack"}, a, e0);
    send_byte(addr, a); chk(a == e1, {req, " addr ack"}, a, e1);
    send_byte(d0, a);   chk(a == e2, {req, " data ack"}, a, e2);
    if (e2) begin
      if (addr == 8'd1) m_vol = d0[6:0];
      if (addr == 8'd0) begin m_pend = 1'b1; m_nv_next = d0[6:0]; m_stop_open = 1'b1; end
    end
    if (nbytes > 1) begin
      send_byte(d1, a); chk(a == 1'b0, "R10 extra data nack", a, 0);
    end
    bus_stop();
    if (m_stop_open) begin m_stop_open = 1'b0; m_busy_until = cyc + BUSY; end
    live = 1'b1;
  endtask

  task automatic do_read(input int addr, input int n, input string req);
    bit a;
    logic [7:0] b;
    int p;
    bus_start();
    send_byte(ID_W, a);       chk(a, {req, " rd id(w) ack"}, a, 1);
    send_byte(8'(addr), a);   chk(a, {req, " rd addr ack"}, a, 1);
    bus_start();
    send_byte(ID_R, a);       chk(a, {req, " rd id(r) ack"}, a, 1);
    p = addr;
    for (int k = 0; k < n; k++) begin
      logic [7:0] e;
      e = m_reg(p);
      recv_byte(b, k < n - 1);
      chk(b == e, {req, " read data"}, b, e);
      p = (p == 2) ? 0 : p + 1;
    end
    bus_stop();
  endtask

  initial begin
    #(CLK_PERIOD * 180000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit a;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    chk(wiper == 7'h40, "R1 wiper reset", wiper, 7'h40);
    live = 1'b1;
    do_read(0, 3, "R1 R4 reset regs");

    // R2 identification mismatches
    do_write(8'h56, 8'h01, 8'h11, 8'h00, 1, "R2 pin mismatch");
    do_write(8'hD4, 8'h01, 8'h11, 8'h00, 1, "R2 prefix mismatch");

    // R3 live wiper write
    do_write(ID_W, 8'h01, 8'h15, 8'h00, 1, "R3 vol write");
    chk(wiper == 7'h15, "R3 wiper out", wiper, 7'h15);
    do_read(1, 1, "R3 readback");

    // R9 bit 7 dropped, control write ignored
    do_write(ID_W, 8'h01, 8'hAA, 8'h00, 1, "R9 bit7");
    do_read(1, 1, "R9 bit7 readback");
    do_write(ID_W, 8'h02, 8'hFF, 8'h00, 1, "R9 ctrl write");
    do_read(2, 1, "R9 ctrl readback");

    // R7 out-of-range address
    do_write(ID_W, 8'h03, 8'h7F, 8'h00, 1, "R7 bad addr");
    do_write(ID_W, 8'h80, 8'h7F, 8'h00, 1, "R7 high addr");

    // R5 stored wiper commit, R6 rejection while busy
    do_write(ID_W, 8'h00, 8'h33, 8'h00, 1, "R5 nv write");
    do_read(2, 1, "R5 wip set");
    do_write(ID_W, 8'h00, 8'h11, 8'h00, 1, "R6 nv write busy");
    do_write(ID_W, 8'h01, 8'h22, 8'h00, 1, "R6 vol write busy");
    do_read(1, 4, "R4 R6 wrap read");
    tick(BUSY + 200);
    do_read(2, 1, "R5 wip clear");
    do_read(0, 1, "R5 nv committed");
    chk(m_nv == 7'h33, "R6 rejected value discarded", m_nv, 7'h33);
    do_write(ID_W, 8'h00, 8'h0C, 8'h00, 1, "R6 nv accepted after busy");
    tick(BUSY + 200);
    do_read(0, 3, "R5 R4 second commit");

    // R10 extra data byte
    do_write(ID_W, 8'h01, 8'h05, 8'h06, 2, "R10 double data");
    chk(wiper == 7'h05, "R10 wiper keeps first", wiper, 7'h05);
    do_read(1, 1, "R10 readback");

    // R8 slave idle on bus after all traffic
    chk(sda_oe == 1'b0, "R8 sda released at end", sda_oe, 0);
    tick(20);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule